// File: doc/BRIEF.md
# Edge-Triggered Converter Host Interface

This block is the host-side control logic of a parallel 8-bit analog-to-digital converter. It watches chip select and the read and write strobes, decides when a conversion begins, passes the start to a separate conversion core, and takes the finished code and overflow bit back from that core. The code and overflow bit are latched together, presented on a data bus with an output enable, and signalled through an active-low end-of-conversion flag.

A static mode input picks one of two ways to start conversions. In write-then-read mode, a falling write strobe starts a conversion and a later read fetches the result. Tying chip select and read low in this mode gives stand-alone operation with the bus always enabled. In read mode, the falling read strobe itself starts the conversion, and the write pin becomes an open-drain ready line that holds the host in its read cycle until fresh data is on the bus. Strobes are synchronised to the system clock. After each conversion a recovery gap of `RECOV_CYC` cycles passes before another start is accepted. Start edges that arrive while the block is busy are dropped and counted.

The result path from the core is a valid/ready channel. `res_ready` is high only while a conversion is in progress. The core holds `res_valid`, `res_data` and `res_ovf` steady until a cycle in which both valid and ready are high. Outside a conversion the block exerts permanent back-pressure, and nothing the core presents is taken.

Top module: `adc_host_if`

## Requirements
- R1: After reset `eoc_n` is 1, `rdy_pd` is 0, `res_ready` is 0, `conv_start` is 0, `ign_cnt` is 0 and `bus_oe` is 0.
- R2: With `mode_wrrd`=1 and chip select low, a falling edge of `wr_n` gives exactly one `conv_start` pulse. The length of the low phase (at least two clock cycles) has no effect on this.
- R3: With `mode_wrrd`=0 and chip select low, a falling edge of `rd_n` starts a conversion and `rdy_pd` is 1 until the result is latched. A `wr_n` edge starts nothing in this mode. With `mode_wrrd`=1, `rdy_pd` stays 0.
- R4: `eoc_n` goes to 0 in the cycle after a result is accepted. It returns to 1 after a rising edge of `rd_n` while chip select is low.
- R5: `bus_oe` is 1 only while both `cs_n` and `rd_n` are low, following them by the synchroniser delay of two cycles.
- R6: While `cs_n` is high, strobe edges start nothing, do not change `ign_cnt`, and do not enable the bus.
- R7: In read mode, the bus shows the previous result from the start of the read until the conversion completes, and the new result from the cycle after acceptance.
- R8: `bus_data` and `ovf_flag` take the accepted `res_data` and `res_ovf` in the same cycle, and hold them until the next acceptance.
- R9: In write-then-read mode with `cs_n` and `rd_n` both held low, `bus_oe` stays 1 across conversions.
- R10: For `RECOV_CYC` cycles after a result is accepted, start edges are ignored. An edge after that gap starts a conversion.
- R11: A start edge that arrives during a conversion or the recovery gap gives no `conv_start` and adds one to `ign_cnt`.
- R12: `res_ready` is 1 only while a conversion is in progress. A result is taken only in a cycle with both `res_valid` and `res_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wrrd | input | 1 | 1 = write-then-read mode, 0 = read mode (static) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| conv_start | output | 1 | One-cycle start pulse to the conversion core |
| res_valid | input | 1 | Core result valid |
| res_ready | output | 1 | Block can accept a result (conversion in progress) |
| res_data | input | DW | Conversion code from the core |
| res_ovf | input | 1 | Overflow bit from the core |
| bus_data | output | DW | Latched conversion code |
| bus_oe | output | 1 | Drive enable for the three-state data bus |
| ovf_flag | output | 1 | Latched overflow bit |
| eoc_n | output | 1 | End of conversion, active low |
| rdy_pd | output | 1 | Pull-down enable of the open-drain ready line |
| ign_cnt | output | IGN_W | Saturating count of ignored start edges |

## Verification
The bench targets start edges that land inside a conversion and inside the recovery gap. A design that let either through would show an extra start pulse and no rise in the ignore count. In read mode it checks that the bus still carries the previous code while ready is held low, and that the code changes only when ready is released: latching too early or too late gives a wrong bus value at one of those two points. It also checks that a long write pulse gives a single start, that a deselected chip ignores both strobes, and that stand-alone operation never disables the bus.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_RECOV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= {sh[STAGES-2:0], async_n[i]};
        prev <= sh[STAGES-1];
      end
    end
    assign lvl[i]  = sh[STAGES-1];
    assign fall[i] = prev & ~sh[STAGES-1];
    assign rise[i] = ~prev & sh[STAGES-1];
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_if_pkg::*;
#(
  parameter int RECOV_CYC = 70,
  parameter int IGN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             res_valid,
  output logic             res_ready,
  output logic             conv_start,
  output logic             done,
  output logic             busy_conv,
  output logic [IGN_W-1:0] ign_cnt
);
  localparam int RW = $clog2(RECOV_CYC + 1);

  seq_state_t    state;
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      rcnt    <= '0;
      ign_cnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE:  if (start_req) state <= SEQ_CONV;
        SEQ_CONV:  if (res_valid) begin
                     state <= SEQ_RECOV;
                     rcnt  <= RW'(RECOV_CYC);
                   end
        SEQ_RECOV: if (rcnt <= RW'(1)) state <= SEQ_IDLE;
                   else rcnt <= rcnt - RW'(1);
        default:   state <= SEQ_IDLE;
      endcase
      if (start_req && state != SEQ_IDLE && ign_cnt != '1)
        ign_cnt <= ign_cnt + IGN_W'(1);
    end
  end

  assign conv_start = start_req && (state == SEQ_IDLE);
  assign res_ready  = (state == SEQ_CONV);
  assign busy_conv  = (state == SEQ_CONV);
  assign done       = res_valid && res_ready;

  AST_RECOV_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RECOV && rcnt > RW'(1)) |=> (state == SEQ_RECOV)); // R10
  AST_IGN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (ign_cnt >= $past(ign_cnt))); // R11
  AST_START_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> res_ready); // R12
endmodule

// File: rtl/adc_out_latch.sv
module adc_out_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] res_data,
  input  logic          res_ovf,
  input  logic          rd_release,
  output logic [DW-1:0] data_q,
  output logic          ovf_q,
  output logic          eoc_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ovf_q  <= 1'b0;
      eoc_n  <= 1'b1;
    end else begin
      if (done) begin
        data_q <= res_data;
        ovf_q  <= res_ovf;
        eoc_n  <= 1'b0;
      end else if (rd_release) begin
        eoc_n  <= 1'b1;
      end
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(data_q) && $stable(ovf_q))); // R8
  AST_EOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !eoc_n); // R4
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RECOV_CYC   = 70,
  parameter int IGN_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wrrd,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic             conv_start,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [DW-1:0]    res_data,
  input  logic             res_ovf,
  output logic [DW-1:0]    bus_data,
  output logic             bus_oe,
  output logic             ovf_flag,
  output logic             eoc_n,
  output logic             rdy_pd,
  output logic [IGN_W-1:0] ign_cnt
);
  localparam int I_CS = 0;
  localparam int I_RD = 1;
  localparam int I_WR = 2;

  logic [2:0] lvl, fall, rise;
  logic       start_req, rd_release, done, busy_conv;
  logic       unused_edges;

  adc_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_n({wr_n, rd_n, cs_n}),
    .lvl    (lvl),
    .fall   (fall),
    .rise   (rise)
  );

  assign unused_edges = ^{fall[I_CS], rise[I_CS], rise[I_WR]};

  assign start_req  = !lvl[I_CS] && (mode_wrrd ? fall[I_WR] : fall[I_RD]);
  assign rd_release = !lvl[I_CS] && rise[I_RD];

  adc_conv_seq #(.RECOV_CYC(RECOV_CYC), .IGN_W(IGN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .conv_start(conv_start),
    .done      (done),
    .busy_conv (busy_conv),
    .ign_cnt   (ign_cnt)
  );

  adc_out_latch #(.DW(DW)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .res_data  (res_data),
    .res_ovf   (res_ovf),
    .rd_release(rd_release),
    .data_q    (bus_data),
    .ovf_q     (ovf_flag),
    .eoc_n     (eoc_n)
  );

  assign bus_oe = !lvl[I_CS] && !lvl[I_RD];
  assign rdy_pd = !mode_wrrd && busy_conv;

  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rdy_pd); // R3
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
endmodule

// File: tb/adc_host_if_test.sv
module adc_host_if_test;
  localparam int DW = 8;
  localparam int RECOV = 70;
  localparam int CONV_LAT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wrrd = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic res_valid = 1'b0, res_ovf = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic conv_start, res_ready, bus_oe, ovf_flag, eoc_n, rdy_pd;
  logic [DW-1:0] bus_data;
  logic [7:0] ign_cnt;

  always #5 clk = ~clk;

  adc_host_if #(.DW(DW), .SYNC_STAGES(2), .RECOV_CYC(RECOV), .IGN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wrrd(mode_wrrd), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .conv_start(conv_start), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_ovf(res_ovf),
    .bus_data(bus_data), .bus_oe(bus_oe), .ovf_flag(ovf_flag), .eoc_n(eoc_n),
    .rdy_pd(rdy_pd), .ign_cnt(ign_cnt)
  );

  int n_chk = 0, n_fail = 0, starts = 0, done_cnt = 0, k = 0;
  logic [DW:0] exp_q[$];
  event hs_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_n = 1'b0; cyc(2); wr_n = 1'b1;
  endtask

  task automatic pulse_rd();
    rd_n = 1'b0; cyc(3); rd_n = 1'b1; cyc(4);
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  function automatic logic [DW:0] code_of(input int idx);
    return {(idx % 3 == 1), 8'(8'h5A + idx * 29)};
  endfunction

  // start counter
  always @(negedge clk) if (rst_n && conv_start) starts++;

  // conversion core model / scoreboard driver
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && conv_start) begin
        logic [DW:0] c;
        cyc(CONV_LAT);
        c = code_of(k);
        res_data = c[DW-1:0];
        res_ovf  = c[DW];
        exp_q.push_back(c);
        res_valid = 1'b1;
        chk(res_ready == 1'b1, "R12 ready during conversion", int'(res_ready), 1);
        @(negedge clk);
        res_valid = 1'b0;
        k++;
        done_cnt++;
        -> hs_ev;
      end
    end
  end

  // monitor: compare latched outputs after each accepted result
  initial begin
    forever begin
      @(hs_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected result", 0, 1);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk({ovf_flag, bus_data} == e, "R8 code and overflow latched together",
            int'({ovf_flag, bus_data}), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(eoc_n == 1'b1, "R1 eoc_n", int'(eoc_n), 1);
    chk(rdy_pd == 1'b0 && res_ready == 1'b0 && conv_start == 1'b0,
        "R1 rdy/ready/start", int'({rdy_pd, res_ready, conv_start}), 0);
    chk(ign_cnt == 0 && bus_oe == 1'b0, "R1 ign_cnt/bus_oe", int'(ign_cnt), 0);

    // R2 short write pulse starts one conversion
    mode_wrrd = 1'b1; cs_n = 1'b0; cyc(3);
    pulse_wr();
    wait_done(1);
    chk(starts == 1, "R2 single start", starts, 1);
    chk(eoc_n == 1'b0, "R4 eoc low after result", int'(eoc_n), 0);
    chk(rdy_pd == 1'b0, "R3 no ready pull in write mode", int'(rdy_pd), 0);
    rd_n = 1'b0; cyc(3);
    chk(bus_oe == 1'b1, "R5 bus enabled with cs and rd low", int'(bus_oe), 1);
    chk(bus_data == code_of(0) & 9'h0FF, "R8 held", int'(bus_data), int'(code_of(0) & 9'h0FF));
    rd_n = 1'b1; cyc(4);
    chk(eoc_n == 1'b1, "R4 eoc high after read", int'(eoc_n), 1);
    chk(bus_oe == 1'b0, "R5 bus released", int'(bus_oe), 0);
    cyc(RECOV + 5);

    // R2 long write pulse still one start
    wr_n = 1'b0; cyc(40); wr_n = 1'b1;
    wait_done(2); cyc(2);
    chk(starts == 2, "R2 long pulse single start", starts, 2);
    pulse_rd(); cyc(RECOV + 5);

    // R11 edge during conversion ignored
    pulse_wr(); cyc(6); pulse_wr();
    wait_done(3); cyc(2);
    chk(starts == 3, "R11 no start during conversion", starts, 3);
    chk(ign_cnt == 1, "R11 ignore count", int'(ign_cnt), 1);
    pulse_rd(); cyc(RECOV + 5);

    // R10 edge inside recovery gap ignored, later edge accepted
    pulse_wr();
    wait_done(4);
    pulse_wr(); cyc(8);
    chk(starts == 4, "R10 no start in recovery", starts, 4);
    chk(ign_cnt == 2, "R10 recovery edge counted", int'(ign_cnt), 2);
    chk(res_ready == 1'b0, "R12 not ready in recovery", int'(res_ready), 0);
    cyc(RECOV);
    pulse_wr(); cyc(4);
    chk(starts == 5, "R10 start after gap", starts, 5);
    wait_done(5);
    pulse_rd(); cyc(RECOV + 5);

    // R6 deselected: strobes ignored
    cs_n = 1'b1; cyc(3);
    pulse_wr();
    rd_n = 1'b0; cyc(4);
    chk(bus_oe == 1'b0, "R6 bus off when deselected", int'(bus_oe), 0);
    rd_n = 1'b1; cyc(6);
    chk(starts == 5 && ign_cnt == 2, "R6 no start, no count", starts, 5);
    chk(eoc_n == 1'b1, "R6 eoc unchanged", int'(eoc_n), 1);

    // R3 / R7 read mode
    mode_wrrd = 1'b0; cs_n = 1'b0; cyc(3);
    pulse_wr(); cyc(6);
    chk(starts == 5 && rdy_pd == 1'b0, "R3 write edge ignored in read mode", starts, 5);
    rd_n = 1'b0; cyc(4);
    chk(rdy_pd == 1'b1, "R3 ready pulled during conversion", int'(rdy_pd), 1);
    chk(bus_oe == 1'b1 && bus_data == (code_of(4) & 9'h0FF), "R7 old code shown",
        int'(bus_data), int'(code_of(4) & 9'h0FF));
    wait_done(6);
    chk(rdy_pd == 1'b0, "R3 ready released at completion", int'(rdy_pd), 0);
    chk(bus_data == (code_of(5) & 9'h0FF), "R7 new code at completion",
        int'(bus_data), int'(code_of(5) & 9'h0FF));
    rd_n = 1'b1; cyc(4);
    chk(eoc_n == 1'b1, "R4 eoc cleared by read in read mode", int'(eoc_n), 1);
    cyc(RECOV + 5);

    // R9 stand-alone
    mode_wrrd = 1'b1; rd_n = 1'b0; cyc(4);
    chk(bus_oe == 1'b1, "R9 enabled stand-alone", int'(bus_oe), 1);
    pulse_wr(); wait_done(7);
    chk(bus_oe == 1'b1, "R9 enabled after first", int'(bus_oe), 1);
    cyc(RECOV + 5);
    pulse_wr(); cyc(5);
    chk(bus_oe == 1'b1, "R9 enabled mid conversion", int'(bus_oe), 1);
    wait_done(8);
    chk(bus_oe == 1'b1 && eoc_n == 1'b0, "R9 enabled after second", int'(bus_oe), 1);
    cyc(4);
    chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule